// File: doc/BRIEF.md
# Daisy-Chainable Three-Wire Register Port for an LED Display Controller

This block is the serial slave through which a host programs the register file of a multiplexed LED display controller. The host frames each transfer with a load strobe. While the strobe is low, data on the serial input is sampled on every rising edge of the serial clock, with the most significant bit first. When the strobe rises, the block inspects the bits it has collected. A frame of 16 bits with the direction bit clear writes one register. A frame of 8 bits with the direction bit set starts a read. For a read, the addressed byte is then shifted out on the serial output, one bit per serial clock edge, while the strobe is held high.

Outside a read, the serial output carries the input bit from sixteen serial clocks earlier. The serial output of one device can therefore feed the serial input of the next, and all devices share the clock and the strobe. A write meant for a device further down the chain is followed by one no-op word for each device in front of it. All devices act together on the strobe edge, and a device that ends up holding a no-op changes nothing.

The serial pins are asynchronous to the system clock. They are brought into the system clock domain through two-flop synchronisers, and their edges are found by comparing successive samples. The register contents drive plain parallel outputs. The diagnostic results are a parallel input that can only be read.

Top module: `disp_serial_if`

## Requirements
- R1: After reset, every register output, the serial output and the write strobe are all 0.
- R2: A frame is accepted as a write when its length is exactly 16 bits and D14 (the second bit sent) is 0. The write places D7:D0 in the register addressed by D13:D8. Digits 0 to 7 are at 0x01 to 0x08. The other writable registers are decode 0x09, global intensity 0x0A, scan limit 0x0B, shutdown 0x0C, feature 0x0E, test 0x0F and the four digit-pair intensities at 0x10 to 0x13.
- R3: A frame of exactly 8 bits with D14 set starts a read, and D13:D8 give the address. Each rising serial clock edge after the strobe rises presents the next bit of the addressed byte on the serial output, from D7 down to D0. The output stays steady between those edges while the strobe is high.
- R4: While the strobe is low, the serial output equals the serial input bit sampled 16 rising serial clock edges earlier, or 0 if fewer than 16 bits have been shifted since reset. Serial clock edges that arrive while the strobe is high shift nothing.
- R5: A frame whose length is a nonzero multiple of 16 acts on its last 16 bits only. Address 0x00 is a no-op and changes no register.
- R6: A write to 0x0A stores the byte there and also sets both nibbles of all four pair intensity registers to its low nibble. A write to one pair register changes only that register.
- R7: A frame of any other length is discarded with no register change and no strobe. This includes a 16-bit frame with D14 set and an 8-bit frame with D14 clear.
- R8: Writes to 0x00, 0x0D and 0x14 to 0x3F are ignored. A read of 0x14+k returns byte k of the diagnostic input (bits 8k+7:8k). A read of 0x00, 0x0D or 0x1C to 0x3F returns 0x00.
- R9: D15 of a write frame (and bit 7 of a read address byte) is ignored.
- R10: The write strobe pulses for exactly one system clock for each accepted write that lands in a writable register. Reads never pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| ld_i | input | 1 | Load strobe; low while shifting, rising edge acts |
| diag_i | input | 64 | Diagnostic result bytes, byte k for digit k |
| sdo_o | output | 1 | Serial data out (chain output or read data) |
| wr_stb_o | output | 1 | One-cycle pulse per accepted register write |
| digit_o | output | 64 | Digit registers, byte k is digit k |
| decode_o | output | 8 | Decode enable register |
| glob_int_o | output | 8 | Global intensity register |
| scan_o | output | 8 | Scan limit register |
| shdn_o | output | 8 | Shutdown register |
| feature_o | output | 8 | Feature register |
| test_o | output | 8 | Test mode register |
| pair_int_o | output | 32 | Pair intensity registers, byte p covers digits 2p and 2p+1 |

## Verification
A wrong bit count or a shift register that slips by one position shows up on the serial output within one serial clock. After that, every chained bit comes out at the wrong time, so the output is compared after every serial clock edge. A write decoded to the wrong register shows up on the parallel outputs a few system clocks after the strobe rises. For that reason every register is compared at the end of every frame, including frames that must be discarded. A fault in the read path shows up on the serial output within eight serial clocks of the strobe edge. The reads cover digit, control, diagnostic and unused addresses.

// File: rtl/disp_serial_pkg.sv
package disp_serial_pkg;

  localparam int DIG_BASE = 1;

  // true when idx lies in [base, base+n)
  function automatic logic in_span(input logic [5:0] idx, input int base, input int n);
    return (int'(idx) >= base) && (int'(idx) < base + n);
  endfunction

endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dsi_shifter.sv
module dsi_shifter #(
  parameter int FRAME_W = 16,
  localparam int HALF   = FRAME_W / 2,
  localparam int CW     = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sdi_s,
  input  logic               ld_s,
  input  logic [HALF-1:0]    rd_byte,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_wr,
  output logic               frame_rd,
  output logic               sdo
);
  logic scl_d, ld_d;
  logic scl_rise, ld_rise, shift_en;
  logic [FRAME_W-1:0] shreg;
  logic [CW-1:0] cnt;
  logic full;
  logic rd_mode, sdo_r;
  logic [HALF-1:0] rdsh;

  // write: count wrapped to zero after at least one full word, direction bit clear
  function automatic logic write_ok(input logic [CW-1:0] c, input logic f, input logic dir);
    return f && (c == '0) && !dir;
  endfunction

  // read: exactly half a word, direction bit set
  function automatic logic read_ok(input logic [CW-1:0] c, input logic f, input logic dir);
    return !f && (c == CW'(HALF)) && dir;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b0;
      ld_d  <= 1'b0;
    end else begin
      scl_d <= scl_s;
      ld_d  <= ld_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign ld_rise  = ld_s & ~ld_d;
  assign shift_en = scl_rise & ~ld_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      full  <= 1'b0;
    end else if (shift_en) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_s};
      cnt   <= cnt + 1'b1;
      if (cnt == CW'(FRAME_W - 1)) full <= 1'b1;
    end else if (ld_s) begin
      cnt  <= '0;
      full <= 1'b0;
    end
  end

  assign frame_wr = ld_rise & write_ok(cnt, full, shreg[FRAME_W-2]);
  assign frame_rd = ld_rise & read_ok(cnt, full, shreg[HALF-2]);
  assign frame_o  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mode <= 1'b0;
      rdsh    <= '0;
      sdo_r   <= 1'b0;
    end else if (frame_rd) begin
      rd_mode <= 1'b1;
      rdsh    <= rd_byte;
      sdo_r   <= shreg[FRAME_W-1];
    end else if (!ld_s) begin
      rd_mode <= 1'b0;
    end else if (rd_mode && scl_rise) begin
      sdo_r <= rdsh[HALF-1];
      rdsh  <= {rdsh[HALF-2:0], 1'b0};
    end
  end

  assign sdo = rd_mode ? sdo_r : shreg[FRAME_W-1];

  AST_NO_SHIFT_LD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(shreg)); // R4
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_wr && frame_rd)); // R7
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && ld_s && !scl_rise) |=> $stable(sdo)); // R3
endmodule

// File: rtl/dsi_regbank.sv
module dsi_regbank
  import disp_serial_pkg::*;
#(
  parameter int NUM_DIG  = 8,
  parameter int DW       = 8,
  localparam int AW      = 6,
  localparam int NUM_PAIR = NUM_DIG / 2,
  localparam int DECODE  = DIG_BASE + NUM_DIG,
  localparam int GLOB    = DECODE + 1,
  localparam int SCAN    = DECODE + 2,
  localparam int SHDN    = DECODE + 3,
  localparam int FEAT    = DECODE + 5,
  localparam int TEST    = DECODE + 6,
  localparam int PAIR_BASE = TEST + 1,
  localparam int DIAG_BASE = PAIR_BASE + NUM_PAIR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_fire,
  input  logic [AW-1:0]          wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_idx,
  input  logic [NUM_DIG*DW-1:0]  diag_i,
  output logic [DW-1:0]          rd_byte,
  output logic                   wr_stb,
  output logic [NUM_DIG*DW-1:0]  dig_flat,
  output logic [NUM_PAIR*DW-1:0] pair_flat,
  output logic [DW-1:0]          dec_q,
  output logic [DW-1:0]          glob_q,
  output logic [DW-1:0]          scan_q,
  output logic [DW-1:0]          shdn_q,
  output logic [DW-1:0]          feat_q,
  output logic [DW-1:0]          test_q
);
  logic writable;
  logic [(NUM_DIG+NUM_PAIR+6)*DW-1:0] all_q;

  assign writable = in_span(wr_idx, DIG_BASE, NUM_DIG) || in_span(wr_idx, DECODE, 4)
                 || in_span(wr_idx, FEAT, 2 + NUM_PAIR);

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_fire && wr_idx == AW'(DIG_BASE + g)) q <= wr_data;
    end
    assign dig_flat[g*DW +: DW] = q;
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_fire && wr_idx == AW'(GLOB)) q <= {2{wr_data[DW/2-1:0]}};
      else if (wr_fire && wr_idx == AW'(PAIR_BASE + p)) q <= wr_data;
    end
    assign pair_flat[p*DW +: DW] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      glob_q <= '0;
      scan_q <= '0;
      shdn_q <= '0;
      feat_q <= '0;
      test_q <= '0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= wr_fire && writable;
      if (wr_fire) begin
        if (wr_idx == AW'(DECODE)) dec_q  <= wr_data;
        if (wr_idx == AW'(GLOB))   glob_q <= wr_data;
        if (wr_idx == AW'(SCAN))   scan_q <= wr_data;
        if (wr_idx == AW'(SHDN))   shdn_q <= wr_data;
        if (wr_idx == AW'(FEAT))   feat_q <= wr_data;
        if (wr_idx == AW'(TEST))   test_q <= wr_data;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_DIG; i++) begin
      if (rd_idx == AW'(DIG_BASE + i))  rd_byte = dig_flat[i*DW +: DW];
      if (rd_idx == AW'(DIAG_BASE + i)) rd_byte = diag_i[i*DW +: DW];
    end
    for (int i = 0; i < NUM_PAIR; i++)
      if (rd_idx == AW'(PAIR_BASE + i)) rd_byte = pair_flat[i*DW +: DW];
    if (rd_idx == AW'(DECODE)) rd_byte = dec_q;
    if (rd_idx == AW'(GLOB))   rd_byte = glob_q;
    if (rd_idx == AW'(SCAN))   rd_byte = scan_q;
    if (rd_idx == AW'(SHDN))   rd_byte = shdn_q;
    if (rd_idx == AW'(FEAT))   rd_byte = feat_q;
    if (rd_idx == AW'(TEST))   rd_byte = test_q;
  end

  assign all_q = {dig_flat, pair_flat, dec_q, glob_q, scan_q, shdn_q, feat_q, test_q};

  AST_NOOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == '0) |=> $stable(all_q)); // R5
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !writable) |=> $stable(all_q)); // R8
  AST_GLOBAL_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_idx == AW'(GLOB)) |=>
      (g_pair[0].q == {2{$past(wr_data[DW/2-1:0])}}) &&
      (g_pair[NUM_PAIR-1].q == {2{$past(wr_data[DW/2-1:0])}})); // R6
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R10
endmodule

// File: rtl/disp_serial_if.sv
module disp_serial_if #(
  parameter int FRAME_W = 16,
  parameter int NUM_DIG = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DW = FRAME_W / 2,
  localparam int AW = DW - 2,
  localparam int NUM_PAIR = NUM_DIG / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sdi_i,
  input  logic                   ld_i,
  input  logic [NUM_DIG*DW-1:0]  diag_i,
  output logic                   sdo_o,
  output logic                   wr_stb_o,
  output logic [NUM_DIG*DW-1:0]  digit_o,
  output logic [DW-1:0]          decode_o,
  output logic [DW-1:0]          glob_int_o,
  output logic [DW-1:0]          scan_o,
  output logic [DW-1:0]          shdn_o,
  output logic [DW-1:0]          feature_o,
  output logic [DW-1:0]          test_o,
  output logic [NUM_PAIR*DW-1:0] pair_int_o
);
  logic scl_s, sdi_s, ld_s;
  logic [FRAME_W-1:0] frame;
  logic frame_wr, frame_rd;
  logic [DW-1:0] rd_byte;
  logic unused_bits;

  dsi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({scl_i, sdi_i, ld_i}),
    .q({scl_s, sdi_s, ld_s})
  );

  dsi_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .scl_s(scl_s), .sdi_s(sdi_s), .ld_s(ld_s),
    .rd_byte(rd_byte),
    .frame_o(frame), .frame_wr(frame_wr), .frame_rd(frame_rd),
    .sdo(sdo_o)
  );

  dsi_regbank #(.NUM_DIG(NUM_DIG), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(frame_wr),
    .wr_idx(frame[DW +: AW]),
    .wr_data(frame[DW-1:0]),
    .rd_idx(frame[AW-1:0]),
    .diag_i(diag_i),
    .rd_byte(rd_byte),
    .wr_stb(wr_stb_o),
    .dig_flat(digit_o),
    .pair_flat(pair_int_o),
    .dec_q(decode_o),
    .glob_q(glob_int_o),
    .scan_q(scan_o),
    .shdn_q(shdn_o),
    .feat_q(feature_o),
    .test_q(test_o)
  );

  assign unused_bits = ^frame[FRAME_W-1:FRAME_W-2];

  AST_SDO_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(sdo_o)); // R4
  AST_READ_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rd |=> !wr_stb_o); // R10
endmodule

// File: tb/tb_disp_serial_if.sv
module tb_disp_serial_if;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl, sdi, ld;
  logic [63:0] diag = 64'h0123_4567_89AB_CDEF;
  logic sdo, wr_stb;
  logic [63:0] digit;
  logic [7:0] dec, glob, scan, shdn, feat, test;
  logic [31:0] pair;

  disp_serial_if dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sdi_i(sdi), .ld_i(ld), .diag_i(diag),
    .sdo_o(sdo), .wr_stb_o(wr_stb), .digit_o(digit), .decode_o(dec),
    .glob_int_o(glob), .scan_o(scan), .shdn_o(shdn), .feature_o(feat),
    .test_o(test), .pair_int_o(pair)
  );

  int n_cmp = 0, n_bad = 0, obs_stb = 0, exp_stb = 0;
  bit done = 0;
  logic [7:0] m_dig [8];
  logic [7:0] m_pair [4];
  logic [7:0] m_dec, m_glob, m_scan, m_shdn, m_feat, m_test;
  bit hist[$];
  bit tx[$];

  always @(posedge clk) if (rst_n && wr_stb) obs_stb++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_writable(input int a);
    return (a >= 1 && a <= 12) || (a >= 14 && a <= 19);
  endfunction

  function automatic logic [7:0] m_read(input int a);
    if (a >= 1 && a <= 8) return m_dig[a-1];
    if (a >= 16 && a <= 19) return m_pair[a-16];
    if (a >= 20 && a <= 27) return diag[(a-20)*8 +: 8];
    case (a)
      9: return m_dec;
      10: return m_glob;
      11: return m_scan;
      12: return m_shdn;
      14: return m_feat;
      15: return m_test;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input int a, input logic [7:0] v);
    if (a >= 1 && a <= 8) m_dig[a-1] = v;
    else if (a >= 16 && a <= 19) m_pair[a-16] = v;
    else if (a == 9) m_dec = v;
    else if (a == 10) begin
      m_glob = v;
      foreach (m_pair[p]) m_pair[p] = {v[3:0], v[3:0]};
    end
    else if (a == 11) m_scan = v;
    else if (a == 12) m_shdn = v;
    else if (a == 14) m_feat = v;
    else if (a == 15) m_test = v;
  endtask

  task automatic check_regs(input string tag);
    logic [63:0] ed;
    logic [31:0] ep;
    foreach (m_dig[k]) ed[k*8 +: 8] = m_dig[k];
    foreach (m_pair[k]) ep[k*8 +: 8] = m_pair[k];
    chk({tag, " digits"}, digit, ed);
    chk({tag, " pairs"}, {32'h0, pair}, {32'h0, ep});
    chk({tag, " ctrl"}, {16'h0, dec, glob, scan, shdn, feat, test},
        {16'h0, m_dec, m_glob, m_scan, m_shdn, m_feat, m_test});
    chk("R10 strobe count", 64'(obs_stb), 64'(exp_stb));
  endtask

  task automatic push16(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) tx.push_back(w[i]);
  endtask

  task automatic push8(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) tx.push_back(w[i]);
  endtask

  task automatic run_frame(input string tag);
    int n;
    logic [15:0] w;
    logic [7:0] a, rb;
    ld = 1'b0;
    repeat (4) @(negedge clk);
    foreach (tx[i]) begin
      sdi = tx[i];
      repeat (6) @(negedge clk);
      scl = 1'b1;
      repeat (6) @(negedge clk);
      hist.push_back(tx[i]);
      chk("R4 chained output", 64'(sdo),
          64'(hist.size() >= 16 ? hist[hist.size()-16] : 1'b0));
      scl = 1'b0;
    end
    repeat (6) @(negedge clk);
    ld = 1'b1;
    repeat (8) @(negedge clk);
    n = tx.size();
    if (n > 0 && n % 16 == 0) begin
      for (int j = 0; j < 16; j++) w[15-j] = tx[n-16+j];
      if (!w[14]) begin
        if (m_writable(int'(w[13:8]))) exp_stb++;
        m_write(int'(w[13:8]), w[7:0]);
      end
    end else if (n == 8) begin
      for (int j = 0; j < 8; j++) a[7-j] = tx[j];
      if (a[6]) begin
        rb = m_read(int'(a[5:0]));
        for (int k = 7; k >= 0; k--) begin
          scl = 1'b1;
          repeat (6) @(negedge clk);
          chk({"R3 read bit ", tag}, 64'(sdo), 64'(rb[k]));
          scl = 1'b0;
          repeat (6) @(negedge clk);
        end
      end
    end
    tx.delete();
    check_regs(tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    scl = 0; sdi = 0; ld = 1; rst_n = 0;
    foreach (m_dig[k]) m_dig[k] = 0;
    foreach (m_pair[k]) m_pair[k] = 0;
    {m_dec, m_glob, m_scan, m_shdn, m_feat, m_test} = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    // R1: reset state
    chk("R1 sdo", 64'(sdo), 64'd0);
    chk("R1 strobe", 64'(wr_stb), 64'd0);
    check_regs("R1");

    // R2: every digit register
    for (int k = 0; k < 8; k++) begin
      push16({8'(k + 1), 8'(8'h11 * (k + 1) ^ 8'h5A)});
      run_frame("R2 digit");
    end
    push16(16'h0907); run_frame("R2 decode");
    push16(16'h0B05); run_frame("R2 scan");
    push16(16'h0C81); run_frame("R2 shutdown");
    push16(16'h0E24); run_frame("R2 feature");
    push16(16'h0F01); run_frame("R2 test");

    // R3: reads of digit and control registers
    push8(8'h44); run_frame("R3 digit3");
    push8(8'h4E); run_frame("R3 feature");

    // R4: SCL pulses with LD high must not shift
    for (int k = 0; k < 3; k++) begin
      scl = 1; repeat (6) @(negedge clk);
      scl = 0; repeat (6) @(negedge clk);
    end
    push16(16'h0199); run_frame("R4 after idle clocks");

    // R6: global fan-out, then single pair
    push16(16'h0A5B); run_frame("R6 global");
    push16(16'h1237); run_frame("R6 pair2");
    push8(8'h52); run_frame("R6 read pair2");

    // R5: chained frames
    push16(16'h01AA); push16(16'h0000); run_frame("R5 noop last");
    push16(16'h0000); push16(16'h0255); run_frame("R5 write last");
    push16(16'h0000); run_frame("R5 lone noop");

    // R7: wrong length or direction
    for (int i = 0; i < 15; i++) tx.push_back(1'b1);
    run_frame("R7 fifteen bits");
    push16(16'h0333); tx.push_back(1'b0); run_frame("R7 seventeen bits");
    push8(8'h03); run_frame("R7 short write");
    push16(16'h4312); run_frame("R7 long read");

    // R8: ignored writes, unused and diagnostic reads
    push16(16'h14FF); run_frame("R8 diag write");
    push16(16'h0DFF); run_frame("R8 unused write");
    push16(16'h3FFF); run_frame("R8 high write");
    push8(8'h4D); run_frame("R8 unused read");
    push8(8'h56); run_frame("R8 diag2 read");
    push8(8'h5B); run_frame("R8 diag7 read");
    push8(8'h40); run_frame("R8 noop read");

    // R9: top bit ignored
    push16(16'h8103); run_frame("R9 write");
    push8(8'hC1); run_frame("R9 read");

    repeat (10) @(negedge clk);
    chk("R10 final strobe count", 64'(obs_stb), 64'(exp_stb));
    finish_run();
  end
endmodule